// File: doc/BRIEF.md
# Bit-Serial Signed Multiplier with Recirculating Partial Sum

This block multiplies two 32-digit two's-complement words one digit per clock. The multiplier word is taken in parallel when an operation starts. The multiplicand then streams in serially, least significant digit first, over the next 32 clocks and is held for the rest of the operation. The partial sum lives in a closed 64-digit loop that turns once per multiplier digit. Each turn is one frame of two 32-pulse halves, and a phase flag marks the first half of every frame. During each frame the stored multiplicand is widened to 64 digits: zeros fill the positions below the genuine digits and copies of its sign digit fill the positions above them. The widened value is shifted by the weight of the current multiplier digit, negated serially when needed, and added into the loop by a single full adder. The adder's carry is cleared on the last pulse of each frame, so a carry out of the top digit never wraps onto the bottom digit.

An add/subtract select picks whether the block delivers +a·b or −a·b. The multiplier's top digit has negative weight, so its frame uses the opposite sign to the one selected. After 32 frames the 64-digit product is shifted out serially, least significant digit first. A one-clock done flag marks the last digit.

Top module: `sermul_mac`

## Requirements
- R1: After reset, `prod_valid`, `prod_bit` and `done` are all 0.
- R2: `start` is accepted on a rising edge while the block is idle. On that edge `mplier` and `subtract` are captured. The multiplicand digits on `mcand_bit` are sampled, least significant first, on the 32 rising edges that follow. Later changes to `mplier` and `subtract` have no effect.
- R3: With `subtract` = 0, the product equals the signed 64-bit two's-complement product of multiplicand and multiplier.
- R4: With `subtract` = 1, the product equals the two's-complement negation of the signed product, modulo 2^64.
- R5: `prod_valid` first reads 1 after the 2080th rising edge that follows the edge that accepted `start`. It then stays at 1 for exactly 64 cycles while `prod_bit` carries the product, least significant digit first.
- R6: `done` is 1 for exactly one cycle, the cycle that carries the 64th product digit. Otherwise it is 0.
- R7: A `start` pulse while an operation is in progress is ignored, and the result of the running operation is unchanged.
- R8: The multiplier's most significant digit has weight −2^31 (for example, a multiplier of all ones times a multiplicand of 1 gives −1).
- R9: The carry is cleared at the last pulse of every frame, so a carry never wraps from the top digit of the 64-digit loop into its bottom digit (for example, (−1)·(−1) = 1).
- R10: The partial sum is cleared when `start` is accepted, so a result does not depend on the previous operation.
- R11: A multiplier digit of 0 adds nothing in either mode, so a zero multiplier gives a zero product whether adding or subtracting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when idle |
| subtract | input | 1 | 1: deliver −a·b, 0: deliver +a·b (captured with start) |
| mplier | input | 32 | Multiplier word (captured with start) |
| mcand_bit | input | 1 | Serial multiplicand digit, least significant first |
| prod_bit | output | 1 | Serial product digit, least significant first |
| prod_valid | output | 1 | High while product digits are being delivered |
| done | output | 1 | One-cycle pulse on the final product digit |

## Verification
Directed operands isolate specific paths:
- Zero operands in both modes show that skipped digits add nothing.
- A multiplier of all ones against a multiplicand of 1 exposes the negative weight of the top multiplier digit.
- (−1)·(−1) and the most negative value squared force long carry chains that would wrap around the 64-digit loop if the carry were not suppressed.
- Extreme positive and negative pairs test the sign-extended padding above the genuine digits.

Seeded random operands in both modes cover mixed carry patterns. One random run injects a second `start` mid-operation with altered inputs to show it is ignored. Large results are followed immediately by small ones, which shows that the loop is cleared on each new operation.

// File: rtl/sermul_pkg.sv
package sermul_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_FRAME = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    typedef struct packed {
        logic digit;
        logic carry;
    } fa_t;

    function automatic fa_t full_add(input logic x, input logic y, input logic ci);
        fa_t r;
        r.digit = x ^ y ^ ci;
        r.carry = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

endpackage

// File: rtl/sermul_seq.sv
module sermul_seq
    import sermul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output phase_e          phase,
    output logic [$clog2(W)-1:0] pulse,
    output logic            odd,
    output logic [$clog2(W)-1:0] didx,
    output logic            accept,
    output logic            frame_last
);
    localparam int PB = $clog2(W);
    localparam logic [PB-1:0] LAST = PB'(W - 1);

    assign accept     = (phase == PH_IDLE) && start;
    assign frame_last = (pulse == LAST) && !odd;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            pulse <= '0;
            odd   <= 1'b0;
            didx  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOAD;
                        pulse <= '0;
                    end
                end
                PH_LOAD: begin
                    if (pulse == LAST) begin
                        phase <= PH_FRAME;
                        pulse <= '0;
                        odd   <= 1'b1;
                        didx  <= '0;
                    end else begin
                        pulse <= pulse + 1'b1;
                    end
                end
                PH_FRAME: begin
                    if (pulse == LAST) begin
                        pulse <= '0;
                        odd   <= ~odd;
                        if (!odd) begin
                            if (didx == LAST) phase <= PH_DRAIN;
                            else              didx  <= didx + 1'b1;
                        end
                    end else begin
                        pulse <= pulse + 1'b1;
                    end
                end
                PH_DRAIN: begin
                    if (pulse == LAST) begin
                        pulse <= '0;
                        odd   <= ~odd;
                        if (!odd) phase <= PH_IDLE;
                    end else begin
                        pulse <= pulse + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R5: the phase flag flips at every half-frame boundary while multiplying
    // R5
    odd_alternates_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FRAME && pulse == LAST) |=> (odd != $past(odd)));

endmodule

// File: rtl/sermul_addend.sv
module sermul_addend #(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_frame,
    input  logic [W-1:0]         mc,
    input  logic                 mbit,
    input  logic                 neg,
    input  logic [$clog2(W):0]   pos,
    input  logic [$clog2(W)-1:0] didx,
    output logic                 addend
);
    localparam int PB = $clog2(W);
    localparam logic [PB:0] POS_END = (PB+1)'(2 * W - 1);

    logic [PB:0] rel;
    logic        below;
    logic        genuine;
    logic        widened;
    logic        raw;
    logic        seen_q;

    always_comb begin
        rel     = pos - {1'b0, didx};
        below   = pos < {1'b0, didx};
        genuine = int'(rel) < W;
        if (below)        widened = 1'b0;
        else if (genuine) widened = mc[rel[PB-1:0]];
        else              widened = mc[W-1];
        raw    = mbit & widened;
        addend = (neg && seen_q) ? ~raw : raw;
    end

    always_ff @(posedge clk) begin
        if (rst || !in_frame || pos == POS_END) seen_q <= 1'b0;
        else                                   seen_q <= seen_q | raw;
    end

    // R11
    zero_digit_adds_nothing_chk: assert property (@(posedge clk) disable iff (rst)
        (in_frame && !mbit) |-> !addend);

endmodule

// File: rtl/sermul_acc.sv
module sermul_acc
    import sermul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic add_en,
    input  logic rotate,
    input  logic addend,
    input  logic frame_last,
    output logic lsb
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ps;
    logic          carry_q;
    fa_t           fa;

    assign fa  = full_add(ps[0], addend, carry_q);
    assign lsb = ps[0];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ps      <= '0;
            carry_q <= 1'b0;
        end else if (add_en) begin
            ps      <= {fa.digit, ps[PW-1:1]};
            carry_q <= frame_last ? 1'b0 : fa.carry;
        end else if (rotate) begin
            ps      <= {ps[0], ps[PW-1:1]};
            carry_q <= 1'b0;
        end
    end

    // R9
    no_wrap_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (add_en && frame_last) |=> !carry_q);

endmodule

// File: rtl/sermul_mac.sv
module sermul_mac
    import sermul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         subtract,
    input  logic [W-1:0] mplier,
    input  logic         mcand_bit,
    output logic         prod_bit,
    output logic         prod_valid,
    output logic         done
);
    localparam int PB = $clog2(W);

    phase_e        phase;
    logic [PB-1:0] pulse;
    logic [PB-1:0] didx;
    logic          odd;
    logic          accept;
    logic          frame_last;
    logic [W-1:0]  mc_q;
    logic [W-1:0]  mplier_q;
    logic          sub_q;
    logic          addend;
    logic          lsb;
    logic          in_frame;
    logic          neg;
    logic [PB:0]   pos;

    sermul_seq #(.W(W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .phase(phase), .pulse(pulse),
        .odd(odd), .didx(didx), .accept(accept), .frame_last(frame_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q     <= '0;
            mplier_q <= '0;
            sub_q    <= 1'b0;
        end else begin
            if (accept) begin
                mplier_q <= mplier;
                sub_q    <= subtract;
            end
            if (phase == PH_LOAD) mc_q <= {mcand_bit, mc_q[W-1:1]};
        end
    end

    assign in_frame = (phase == PH_FRAME);
    assign pos      = {~odd, pulse};
    assign neg      = sub_q ^ (didx == PB'(W - 1));

    sermul_addend #(.W(W)) u_addend (
        .clk(clk), .rst(rst), .in_frame(in_frame), .mc(mc_q),
        .mbit(mplier_q[didx]), .neg(neg), .pos(pos), .didx(didx), .addend(addend)
    );

    sermul_acc #(.W(W)) u_acc (
        .clk(clk), .rst(rst), .clear(accept), .add_en(in_frame),
        .rotate(phase == PH_DRAIN), .addend(addend), .frame_last(frame_last), .lsb(lsb)
    );

    assign prod_valid = (phase == PH_DRAIN);
    assign prod_bit   = prod_valid & lsb;
    assign done       = prod_valid & frame_last;

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && start) |=> ($stable(mplier_q) && $stable(sub_q)));

    // R6
    done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> prod_valid);

endmodule

// File: tb/sermul_mac_test.sv
module sermul_mac_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        subtract = 1'b0;
    logic [31:0] mplier = '0;
    logic        mcand_bit = 1'b0;
    logic        prod_bit;
    logic        prod_valid;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sermul_mac #(.W(32)) uut (
        .clk(clk), .rst(rst), .start(start), .subtract(subtract), .mplier(mplier),
        .mcand_bit(mcand_bit), .prod_bit(prod_bit), .prod_valid(prod_valid), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ref_prod(input logic [31:0] a, input logic [31:0] b, input bit sub);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        return sub ? -p : p;
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit sub,
                          input bit poke, input string req);
        int          cyc;
        int          done_cnt;
        int          bad_valid;
        logic [63:0] got;
        longint      exp;
        exp = ref_prod(a, b, sub);
        @(negedge clk);
        start = 1'b1; subtract = sub; mplier = b;
        cyc = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            mplier = ~b;          // R2: later input changes must not matter
            subtract = ~sub;
            mcand_bit = a[i];
        end
        while (!prod_valid && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 500) start = 1'b1;   // R7: start while busy
            else start = 1'b0;
        end
        chk(cyc == 2081, "R5 latency", cyc, 2081);
        done_cnt = 0; bad_valid = 0; got = '0;
        for (int k = 0; k < 64; k++) begin
            got[k] = prod_bit;
            if (!prod_valid) bad_valid++;
            if (done) begin
                done_cnt++;
                if (k != 63) bad_valid++;
            end
            @(negedge clk);
        end
        chk(bad_valid == 0 && done_cnt == 1, "R6 done/valid framing", done_cnt, 1);
        chk(!prod_valid && !done, "R5 valid ends after 64", prod_valid, 0);
        chk(got == exp, req, longint'(got), exp);
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!prod_valid && !prod_bit && !done, "R1 reset state",
            {prod_valid, prod_bit, done}, 0);

        run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R3 min*min");
        // R10: small result straight after a large one
        run_op(32'd12345, 32'd0, 1'b0, 1'b0, "R10 R11 zero after large");
        run_op(32'd777, 32'd0, 1'b1, 1'b0, "R11 zero multiplier subtract");
        run_op(32'd1, 32'd1, 1'b0, 1'b0, "R3 one*one");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9 minus1*minus1");
        run_op(32'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 one*minus1");
        run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, "R3 max*max");
        run_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, "R4 min*max subtract");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 min*minus1");
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R4 min*min subtract");
        run_op(32'd3, 32'd5, 1'b1, 1'b0, "R4 small subtract");
        run_op($urandom, $urandom, 1'b0, 1'b1, "R7 busy start ignored");
        for (int n = 0; n < 8; n++) begin
            automatic logic [31:0] ra = $urandom;
            automatic logic [31:0] rb = $urandom;
            automatic bit rs = n[0];
            run_op(ra, rb, rs, 1'b0, rs ? "R4 random subtract" : "R3 random add");
        end
        run_op(32'd0, 32'h1234_5678, 1'b0, 1'b0, "R2 R10 zero multiplicand");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule